// File: doc/BRIEF.md
# Timebase Interval Timer Controller

This block keeps a free-running counter on the main clock and turns one of its bit positions into a periodic event. Software picks which bit to use through a 3-bit interval code in a byte-wide control register. Each time the selected bit carries, a request flag is set. While the enable bit in the same register is 1, a registered interrupt line is asserted. The same byte also holds two mode bits. Neighbouring reset and standby logic reads them: one picks a synchronous reset over a normal reset, and one must be set before any standby mode is entered.

The eight intervals are not contiguous. The three short codes take the carries of bits 11, 12 and 13. The five long codes take bits 22 through 26. All of these exponents are parameters. The register is reached through a single-cycle port with separate read and write strobes. There is also a read-modify-write qualifier, so a read-modify-write cycle cannot clear a pending request by accident.

Two resets act on the block. The hard reset is asynchronous and active-low, and its release passes through a synchroniser. It clears the whole register and the counter. The synchronous software reset clears only the request flag and the enable. The counter and the other fields keep their values through it.

Top module: `timebase_ctl`

## Requirements
- R1: Hard reset drives the irq output and both mode outputs low at once. After release, a plain read returns 0x00, because the interval code resets to 000 in this implementation.
- R2: The control byte layout is: bit 7 request flag, bit 6 interrupt enable, bits 5..3 interval code, bit 2 reserved, bit 1 synchronous-reset mode, bit 0 synchronous-standby mode. Interval code c sets the flag every 2^(LO_EXP+c) clocks for c = 0..2, and every 2^(HI_EXP+c-3) clocks for c = 3..7. With the default parameters these periods are 2^11, 2^12, 2^13, 2^22, 2^23, 2^24, 2^25 and 2^26.
- R3: The flag is set on its period whether or not the enable is 1. The irq output is high exactly one clock after the flag and the enable are both 1, and it stays low while the enable is 0.
- R4: A write with bit 7 = 0 clears the flag. A write with bit 7 = 1 leaves the flag unchanged.
- R5: When a tap carry and a flag-clearing write fall in the same clock, the flag stays set.
- R6: A software reset pulse clears the flag and the enable. It keeps the interval code and both mode bits, and it does not disturb the counter phase.
- R7: A read with the read-modify-write qualifier returns bit 7 as 1. A plain read returns the true flag value.
- R8: Writes to bit 2 have no effect, and bit 2 always reads as 0.
- R9: Bits 1 and 0 are written and read back like ordinary bits. They drive the sync_rst_en and sync_stby_en outputs directly.
- R10: Writing a new interval code does not restart the counter. Flag events under any code fall on the same counter phase, so the first event after a code change lines up with that code's period grid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Hard reset, asynchronous assert, active low |
| soft_rst | input | 1 | Synchronous software reset pulse |
| reg_wr | input | 1 | Write strobe for the control byte |
| reg_rd | input | 1 | Read strobe for the control byte |
| reg_rmw | input | 1 | Marks a read as part of a read-modify-write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high, otherwise 0 |
| irq | output | 1 | Registered interrupt level |
| sync_rst_en | output | 1 | Synchronous reset mode bit |
| sync_stby_en | output | 1 | Synchronous standby mode bit |

## Verification
The tap selection is tested by running every interval code on a shortened counter. For each code the bench measures the spacing between two interrupt rises, which separates correct codes from swapped or off-by-one tap positions. It also checks the absolute phase of the first rise after each code change against a phase learned on the longest code, which reveals any counter restart on a register write. Clears are timed two ways: once away from a carry, where the flag must drop, and once on exactly the carry clock, where the flag must survive. Separate patterns cover the enable held at 0 during a period, a software reset while a request is pending, and writes that set the reserved bit.

// File: rtl/timebase_pkg.sv
package timebase_pkg;

  localparam int CTL_W      = 8;
  localparam int CODE_W     = 3;
  localparam int NUM_TAPS   = 1 << CODE_W;
  localparam int NUM_LOW    = 3;

  // bit positions that the reset and standby neighbours decode
  localparam int POS_FLAG   = 7;
  localparam int POS_IEN    = 6;
  localparam int POS_CODE   = 3;
  localparam int POS_RSVD   = 2;
  localparam int POS_SRST   = 1;
  localparam int POS_SSTBY  = 0;

  typedef struct packed {
    logic              flag;
    logic              ien;
    logic [CODE_W-1:0] code;
    logic              srst_mode;
    logic              sstby_mode;
  } tb_ctl_t;

  // Exponent of the period chosen by an interval code.
  function automatic int tap_exp(input int code, input int lo, input int hi);
    if (code < NUM_LOW) return lo + code;
    else                return hi + code - NUM_LOW;
  endfunction

endpackage

// File: rtl/tbt_rst_sync.sv
module tbt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = sync_q[STAGES-1];

endmodule

// File: rtl/tbt_counter.sv
module tbt_counter
  import timebase_pkg::*;
#(
  parameter int CNT_W  = 26,
  parameter int LO_EXP = 11,
  parameter int HI_EXP = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  output logic              tap_tick
);

  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    cnt_d;
  logic [NUM_TAPS-1:0] tap_hit;

  always_comb begin
    cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // A tap fires in the clock where its low bits are all ones,
  // i.e. the clock whose increment carries out of that bit field.
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int EXP = tap_exp(g, LO_EXP, HI_EXP);
    assign tap_hit[g] = &cnt_q[EXP-1:0];
  end

  assign tap_tick = tap_hit[code];

endmodule

// File: rtl/tbt_ctl_reg.sv
module tbt_ctl_reg
  import timebase_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr,
  input  logic             rd,
  input  logic             rmw,
  input  logic [CTL_W-1:0] wdata,
  input  logic             tap_tick,
  output tb_ctl_t          ctl_q,
  output logic [CTL_W-1:0] rdata
);

  tb_ctl_t ctl_d;
  logic    ctl_ld;

  always_comb begin
    ctl_d = ctl_q;
    if (wr) begin
      ctl_d.ien        = wdata[POS_IEN];
      ctl_d.code       = wdata[POS_CODE +: CODE_W];
      ctl_d.srst_mode  = wdata[POS_SRST];
      ctl_d.sstby_mode = wdata[POS_SSTBY];
      if (!wdata[POS_FLAG]) ctl_d.flag = 1'b0;
    end
    if (tap_tick) ctl_d.flag = 1'b1;
    if (soft_rst) begin
      ctl_d.flag = 1'b0;
      ctl_d.ien  = 1'b0;
    end
  end

  assign ctl_ld = wr | tap_tick | soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_ld) ctl_q <= ctl_d;
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      rdata[POS_FLAG]             = ctl_q.flag | rmw;
      rdata[POS_IEN]              = ctl_q.ien;
      rdata[POS_CODE +: CODE_W]   = ctl_q.code;
      rdata[POS_RSVD]             = 1'b0;
      rdata[POS_SRST]             = ctl_q.srst_mode;
      rdata[POS_SSTBY]            = ctl_q.sstby_mode;
    end
  end

endmodule

// File: rtl/tbt_irq_out.sv
module tbt_irq_out (
  input  logic clk,
  input  logic rst_n,
  input  logic flag,
  input  logic ien,
  output logic irq
);

  logic irq_d;

  always_comb begin
    irq_d = flag & ien;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

endmodule

// File: rtl/timebase_ctl.sv
module timebase_ctl
  import timebase_pkg::*;
#(
  parameter int CNT_W  = 26,
  parameter int LO_EXP = 11,
  parameter int HI_EXP = 22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic       reg_rmw,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       sync_rst_en,
  output logic       sync_stby_en
);

  localparam int TOP_EXP = tap_exp(NUM_TAPS-1, LO_EXP, HI_EXP);

  logic    rst_core_n;
  logic    tap_tick;
  tb_ctl_t ctl_q;

  initial begin
    if (TOP_EXP > CNT_W) $error("counter narrower than longest tap");
  end

  tbt_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  tbt_counter #(
    .CNT_W  (CNT_W),
    .LO_EXP (LO_EXP),
    .HI_EXP (HI_EXP)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .code     (ctl_q.code),
    .tap_tick (tap_tick)
  );

  tbt_ctl_reg u_ctl_reg (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .soft_rst (soft_rst),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .rmw      (reg_rmw),
    .wdata    (reg_wdata),
    .tap_tick (tap_tick),
    .ctl_q    (ctl_q),
    .rdata    (reg_rdata)
  );

  tbt_irq_out u_irq_out (
    .clk   (clk),
    .rst_n (rst_core_n),
    .flag  (ctl_q.flag),
    .ien   (ctl_q.ien),
    .irq   (irq)
  );

  assign sync_rst_en  = ctl_q.srst_mode;
  assign sync_stby_en = ctl_q.sstby_mode;

endmodule

// File: rtl/timebase_ctl_chk.sv
module timebase_ctl_chk
  import timebase_pkg::*;
(
  input logic       clk,
  input logic       rst_core_n,
  input logic       soft_rst,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic       reg_rmw,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       tap_tick,
  input tb_ctl_t    ctl_q,
  input logic       irq,
  input logic       sync_rst_en,
  input logic       sync_stby_en
);

  a_r2_flag_from_tick: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(ctl_q.flag) |-> $past(tap_tick));

  a_r3_irq_low_when_disabled: assert property (@(posedge clk) disable iff (!rst_core_n)
    !ctl_q.ien |=> !irq);

  a_r3_irq_follows_request: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ctl_q.flag && ctl_q.ien) |=> irq);

  a_r4_write_clears: assert property (@(posedge clk) disable iff (!rst_core_n)
    (reg_wr && !reg_wdata[7] && !tap_tick) |=> !ctl_q.flag);

  a_r5_tick_wins: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tap_tick && !soft_rst) |=> ctl_q.flag);

  a_r6_soft_clears: assert property (@(posedge clk) disable iff (!rst_core_n)
    soft_rst |=> (!ctl_q.flag && !ctl_q.ien));

  a_r6_soft_keeps: assert property (@(posedge clk) disable iff (!rst_core_n)
    (soft_rst && !reg_wr) |=> $stable(ctl_q.code) && $stable(sync_rst_en) && $stable(sync_stby_en));

  a_r7_rmw_reads_one: assert property (@(posedge clk) disable iff (!rst_core_n)
    (reg_rd && reg_rmw) |-> reg_rdata[7]);

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_core_n)
    reg_rd |-> !reg_rdata[2]);

  a_r9_modes_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    !reg_wr |=> $stable({sync_rst_en, sync_stby_en}));

endmodule

bind timebase_ctl timebase_ctl_chk u_chk (
  .clk          (clk),
  .rst_core_n   (rst_core_n),
  .soft_rst     (soft_rst),
  .reg_wr       (reg_wr),
  .reg_rd       (reg_rd),
  .reg_rmw      (reg_rmw),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .tap_tick     (tap_tick),
  .ctl_q        (ctl_q),
  .irq          (irq),
  .sync_rst_en  (sync_rst_en),
  .sync_stby_en (sync_stby_en)
);

// File: tb/timebase_ctl_tb.sv
module timebase_ctl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LO = 3;
  localparam int HI = 6;
  localparam int CW = 10;

  logic       clk;
  logic       rst_n;
  logic       soft_rst;
  logic       reg_wr, reg_rd, reg_rmw;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq, sync_rst_en, sync_stby_en;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  timebase_ctl #(.CNT_W(CW), .LO_EXP(LO), .HI_EXP(HI)) u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rmw(reg_rmw),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sync_rst_en(sync_rst_en), .sync_stby_en(sync_stby_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int period_of(input int c);
    return (c < 3) ? (1 << (LO + c)) : (1 << (HI + c - 3));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares read data a little after each negedge
  always @(negedge clk) begin
    #2;
    if (reg_rd) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard underflow", 0, 1);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(reg_rdata == e, t, reg_rdata, e);
      end
    end
  end

  task automatic bus_write(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic bus_read(input logic [7:0] e, input bit rmw, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    reg_rd = 1'b1; reg_rmw = rmw;
    @(negedge clk);
    reg_rd = 1'b0; reg_rmw = 1'b0;
  endtask

  task automatic wait_rise(output int when, input int limit, input string tag);
    logic prev;
    bit got;
    prev = irq; got = 0; when = 0;
    for (int i = 0; i < limit && !got; i++) begin
      @(negedge clk);
      if (irq && !prev) begin got = 1; when = cyc; end
      prev = irq;
    end
    if (!got) check(1'b0, tag, 0, 1);
  endtask

  initial begin
    int r1, r2, k;
    logic [7:0] w;
    rst_n = 1'b0; soft_rst = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_rmw = 1'b0; reg_wdata = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(irq == 1'b0, "R1 irq after reset", irq, 0);
    check({sync_rst_en, sync_stby_en} == 2'b00, "R1 modes after reset", {sync_rst_en, sync_stby_en}, 0);
    bus_read(8'h00, 0, "R1 reset read");

    // R2/R10 longest code: learn phase and period
    bus_write(8'h78);
    wait_rise(r1, 3000, "R2 code7 first event");
    bus_write(8'h78);
    wait_rise(r2, 1100, "R2 code7 second event");
    check(r2 - r1 == 1024, "R2 code7 period", r2 - r1, 1024);
    k = r1 % 1024;

    for (int c = 0; c < 7; c++) begin
      int p;
      p = period_of(c);
      w = {2'b01, c[2:0], 3'b000};
      bus_write(w);
      wait_rise(r1, 2 * p + 4, "R2 code event");
      check((r1 % p) == (k % p), "R10 phase after code change", r1 % p, k % p);
      bus_write(w);
      wait_rise(r2, 2 * p + 4, "R2 code event");
      check(r2 - r1 == p, "R2 period for code", r2 - r1, p);
    end

    // R3 enable off: flag sets, irq stays low
    bus_write(8'h00);
    begin
      bit seen;
      seen = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (irq) seen = 1;
      end
      check(!seen, "R3 irq held low with enable 0", seen, 0);
    end
    bus_read(8'h80, 0, "R3 flag sets with enable 0");
    // R4 writing 1 to flag keeps it
    bus_write(8'hC0);
    bus_read(8'hC0, 0, "R4 write one keeps flag");
    @(negedge clk);
    check(irq == 1'b1, "R3 irq with flag and enable", irq, 1);

    // R4 clear away from a carry, R5 clear on a carry
    bus_write(8'h50);
    wait_rise(r1, 80, "R4 code2 event");
    bus_write(8'h50);
    bus_read(8'h50, 0, "R4 write zero clears flag");
    repeat (60) @(negedge clk);
    bus_write(8'h50);
    bus_read(8'hD0, 0, "R5 carry beats clear");

    // R7 / R8 / R9
    bus_write(8'h50);
    bus_read(8'hD0, 1, "R7 rmw read shows flag one");
    bus_read(8'h50, 0, "R7 plain read shows flag zero");
    bus_write(8'h57);
    bus_read(8'h53, 0, "R8 reserved bit ignored");
    check({sync_rst_en, sync_stby_en} == 2'b11, "R9 mode outputs 11", {sync_rst_en, sync_stby_en}, 3);
    bus_write(8'h52);
    bus_read(8'h52, 0, "R9 mode bits readback");
    check({sync_rst_en, sync_stby_en} == 2'b10, "R9 mode outputs 10", {sync_rst_en, sync_stby_en}, 2);

    // R6 software reset with a pending request
    bus_write(8'h5B);
    wait_rise(r1, 140, "R6 code3 event");
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    bus_read(8'h1B, 0, "R6 soft reset clears flag and enable only");
    check(irq == 1'b0, "R6 irq low after soft reset", irq, 0);
    check({sync_rst_en, sync_stby_en} == 2'b11, "R6 modes kept", {sync_rst_en, sync_stby_en}, 3);
    bus_write(8'h58);
    wait_rise(r1, 140, "R6 event after soft reset");
    check((r1 % 64) == (k % 64), "R6 counter phase kept", r1 % 64, k % 64);

    // R1 hard reset asserted mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(irq == 1'b0, "R1 irq cleared by hard reset", irq, 0);
    check({sync_rst_en, sync_stby_en} == 2'b00, "R1 modes cleared by hard reset", {sync_rst_en, sync_stby_en}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(8'h00, 0, "R1 read after hard reset");
    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    wait (done || cyc > 150000);
    if (!done) check(1'b0, "watchdog expired", cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule